// File: doc/BRIEF.md
# Parallel Flash Unlock Command Decoder

This block is the command interpreter that sits behind the write port of a word-wide parallel NOR-style memory. Each bus write cycle presents an address and a data word. The decoder walks a fixed chain of unlock address/data pairs and recognises three- and six-cycle protected commands. It turns a completed program, sector erase, block erase or chip erase command into a one-cycle start pulse. The target address and data are latched with the pulse. Other commands switch the read path into an identification mode or a query mode. Only address bits 14..0 and data bits 7..0 take part in the comparison.

After a start pulse the decoder raises `busy` for a programmable number of clock cycles. During that time every write is discarded. When `busy` falls, the sequencer is back in its idle state. A write that does not fit the expected sequence aborts it: the sequencer returns to idle and the mode returns to normal read.

Sequencer states: `SQ_IDLE` (no cycle matched), `SQ_UNLK1` (first unlock pair seen), `SQ_UNLK2` (second unlock pair seen, command cycle expected), `SQ_WORD` (program armed, word cycle expected), `SQ_ERS_ARM` (erase armed), `SQ_ERS_U1` and `SQ_ERS_U2` (the repeated unlock pairs of an erase), and `SQ_BUSY` (lockout). Transitions:
- `SQ_IDLE` to `SQ_UNLK1` on AAh at 5555h.
- `SQ_UNLK1` to `SQ_UNLK2` on 55h at 2AAAh.
- `SQ_UNLK2` to one of the following on a write at 5555h:
  - `SQ_WORD` with A0h.
  - `SQ_ERS_ARM` with 80h.
  - `SQ_IDLE` with 90h, 98h or F0h, which change the mode.
- `SQ_ERS_ARM` to `SQ_ERS_U1` on AAh at 5555h.
- `SQ_ERS_U1` to `SQ_ERS_U2` on 55h at 2AAAh.
- `SQ_WORD` to `SQ_BUSY` on any write.
- `SQ_ERS_U2` to `SQ_BUSY` on one of these writes:
  - 30h at any address.
  - 50h at any address.
  - 10h at 5555h.
- `SQ_BUSY` to `SQ_IDLE` when the busy count expires.
- Any other write in a non-busy state goes to `SQ_IDLE` with read mode.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After synchronous reset, `mode` is 0 (read), `busy` is 0, all four start pulses are 0 and `id_word` is 0000h.
- R2: The writes AAh@5555h, 55h@2AAAh, A0h@5555h followed by any write W produce `pgm_start` high for exactly one cycle, in the cycle after W is captured. In that cycle `tgt_addr` equals W's full address and `tgt_data` equals W's full data.
- R3: The six writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 30h@A produce `sec_start`. In the same cycle `tgt_addr` is A with bits SECT_BITS-1..0 cleared and `tgt_data` is FFFFh.
- R4: The same six-cycle chain ending in 50h@A produces `blk_start`. In the same cycle `tgt_addr` is A with bits BLK_BITS-1..0 cleared and `tgt_data` is FFFFh.
- R5: The same six-cycle chain ending in 10h@5555h produces `chip_start` with `tgt_addr` 0. A final 10h at any other address starts nothing.
- R6: AAh@5555h, 55h@2AAAh, 90h@5555h set `mode` to 1 (identification). In that mode, `id_word` is 00BFh when `rd_addr` is 0, 2783h when `rd_addr` is 1, and 0000h otherwise. In any other mode `id_word` is 0000h.
- R7: AAh@5555h, 55h@2AAAh, 98h@5555h set `mode` to 2 (query). Mode encoding 3 never occurs.
- R8: A single write of F0h at any address in idle leaves identification or query mode and returns `mode` to 0. So does the sequence AAh@5555h, 55h@2AAAh, F0h@5555h, and `mode` stays unchanged until that sequence's last write.
- R9: Any write that does not match the next expected cycle returns the sequencer to idle and `mode` to 0. A later command must restart from the first unlock cycle.
- R10: `busy` rises in the cycle of a start pulse and stays high for max(`busy_len`,1) cycles. While it is high, every write is ignored: no mode change and no sequence progress. When it falls, the sequencer is idle.
- R11: Only address bits 14..0 and data bits 7..0 are compared. Any value in the upper address or data bits is accepted during a sequence.
- R12: At most one start pulse is high in any cycle, and no start pulse lasts more than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Bus write cycle strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 16 | Write data |
| busy_len | input | CNT_W | Busy duration in cycles (0 acts as 1) |
| rd_addr | input | ADDR_W | Read offset for the identification words |
| mode | output | 2 | 0 read, 1 identification, 2 query |
| pgm_start | output | 1 | One-cycle word program start |
| sec_start | output | 1 | One-cycle sector erase start |
| blk_start | output | 1 | One-cycle block erase start |
| chip_start | output | 1 | One-cycle chip erase start |
| tgt_addr | output | ADDR_W | Latched target address |
| tgt_data | output | 16 | Latched word data (FFFFh for erases) |
| busy | output | 1 | Internal operation in progress |
| id_word | output | 16 | Identification read word |

## Verification
A write is captured at the rising edge on which `wr_en` is high. The resulting changes to `mode`, the start pulses, `tgt_addr`, `tgt_data` and `busy` are visible in the cycle right after that edge. `id_word` follows `mode` and `rd_addr` within the same cycle.

The bench drives each write on a falling edge and drops `wr_en` at the next falling edge. It checks pulses and latched targets at that second falling edge. One falling edge later it confirms that the pulse has gone. The busy window is measured by counting falling edges until `busy` drops and comparing the count with `busy_len`.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_UNLK1,
        SQ_UNLK2,
        SQ_WORD,
        SQ_ERS_ARM,
        SQ_ERS_U1,
        SQ_ERS_U2,
        SQ_BUSY
    } seq_state_t;

    typedef enum logic [1:0] {
        MD_READ  = 2'd0,
        MD_IDENT = 2'd1,
        MD_QUERY = 2'd2
    } mode_t;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_PGM,
        ACT_SEC,
        ACT_BLK,
        ACT_CHIP
    } act_t;

    localparam int KEY_AW = 15;
    localparam int KEY_DW = 8;

    localparam logic [KEY_AW-1:0] KEY_ADDR_A = 15'h5555;
    localparam logic [KEY_AW-1:0] KEY_ADDR_B = 15'h2AAA;
    localparam logic [KEY_DW-1:0] KEY_DATA_A = 8'hAA;
    localparam logic [KEY_DW-1:0] KEY_DATA_B = 8'h55;

    localparam logic [KEY_DW-1:0] OP_PROGRAM = 8'hA0;
    localparam logic [KEY_DW-1:0] OP_ERASE   = 8'h80;
    localparam logic [KEY_DW-1:0] OP_SECTOR  = 8'h30;
    localparam logic [KEY_DW-1:0] OP_BLOCK   = 8'h50;
    localparam logic [KEY_DW-1:0] OP_CHIP    = 8'h10;
    localparam logic [KEY_DW-1:0] OP_IDENT   = 8'h90;
    localparam logic [KEY_DW-1:0] OP_QUERY   = 8'h98;
    localparam logic [KEY_DW-1:0] OP_EXIT    = 8'hF0;

    localparam logic [15:0] MAKER_CODE = 16'h00BF;
    localparam logic [15:0] PART_CODE  = 16'h2783;

endpackage

// File: rtl/nor_cycle_classify.sv
module nor_cycle_classify
    import nor_cmd_pkg::*;
(
    input  logic [KEY_AW-1:0] addr_lo,
    input  logic [KEY_DW-1:0] data_lo,
    output logic              key_a,
    output logic              key_b,
    output logic              at_key,
    output logic [KEY_DW-1:0] op
);
    always_comb begin
        at_key = (addr_lo == KEY_ADDR_A);
        key_a  = at_key && (data_lo == KEY_DATA_A);
        key_b  = (addr_lo == KEY_ADDR_B) && (data_lo == KEY_DATA_B);
        op     = data_lo;
    end
endmodule

// File: rtl/nor_busy_timer.sv
module nor_busy_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= (len == '0) ? ONE : len;
        end else if (cnt != '0) begin
            cnt <= cnt - ONE;
        end
    end

    assign expire = (cnt == ONE);
endmodule

// File: rtl/nor_target_fmt.sv
module nor_target_fmt
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W    = 21,
    parameter int SECT_BITS = 11,
    parameter int BLK_BITS  = 15
) (
    input  act_t              act,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] tgt
);
    localparam logic [ADDR_W-1:0] ALL_ONES  = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] SECT_MASK = ALL_ONES << SECT_BITS;
    localparam logic [ADDR_W-1:0] BLK_MASK  = ALL_ONES << BLK_BITS;

    always_comb begin
        unique case (act)
            ACT_SEC:  tgt = addr & SECT_MASK;
            ACT_BLK:  tgt = addr & BLK_MASK;
            ACT_CHIP: tgt = '0;
            default:  tgt = addr;
        endcase
    end
endmodule

// File: rtl/nor_id_rom.sv
module nor_id_rom
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input  mode_t             mode,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [15:0]       id_word
);
    always_comb begin
        id_word = 16'h0000;
        if (mode == MD_IDENT) begin
            if (rd_addr == ADDR_W'(0))      id_word = MAKER_CODE;
            else if (rd_addr == ADDR_W'(1)) id_word = PART_CODE;
        end
    end
endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W    = 21,
    parameter int CNT_W     = 16,
    parameter int SECT_BITS = 11,
    parameter int BLK_BITS  = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [CNT_W-1:0]  busy_len,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [1:0]        mode,
    output logic              pgm_start,
    output logic              sec_start,
    output logic              blk_start,
    output logic              chip_start,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [15:0]       tgt_data,
    output logic              busy,
    output logic [15:0]       id_word
);
    seq_state_t        state, state_d;
    mode_t             mode_q, mode_d;
    act_t              act;
    logic              key_a, key_b, at_key, expire;
    logic [KEY_DW-1:0] op;
    logic [ADDR_W-1:0] tgt_fmt;

    nor_cycle_classify u_cls (
        .addr_lo (wr_addr[KEY_AW-1:0]),
        .data_lo (wr_data[KEY_DW-1:0]),
        .key_a   (key_a),
        .key_b   (key_b),
        .at_key  (at_key),
        .op      (op)
    );

    nor_busy_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .load   (act != ACT_NONE),
        .len    (busy_len),
        .expire (expire)
    );

    nor_target_fmt #(
        .ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS), .BLK_BITS(BLK_BITS)
    ) u_fmt (
        .act  (act),
        .addr (wr_addr),
        .tgt  (tgt_fmt)
    );

    nor_id_rom #(.ADDR_W(ADDR_W)) u_rom (
        .mode    (mode_q),
        .rd_addr (rd_addr),
        .id_word (id_word)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= SQ_IDLE;
        else     state <= state_d;
    end

    // Next state, pending action and next mode
    always_comb begin
        state_d = state;
        mode_d  = mode_q;
        act     = ACT_NONE;
        unique case (state)
            SQ_BUSY: begin
                if (expire) state_d = SQ_IDLE;
            end
            SQ_IDLE: begin
                if (wr_en) begin
                    if (key_a) state_d = SQ_UNLK1;
                    else       mode_d  = MD_READ;
                end
            end
            SQ_UNLK1: begin
                if (wr_en) begin
                    if (key_b) state_d = SQ_UNLK2;
                    else begin state_d = SQ_IDLE; mode_d = MD_READ; end
                end
            end
            SQ_UNLK2: begin
                if (wr_en) begin
                    state_d = SQ_IDLE;
                    mode_d  = MD_READ;
                    if (at_key) begin
                        if (op == OP_PROGRAM)    begin state_d = SQ_WORD;    mode_d = mode_q; end
                        else if (op == OP_ERASE) begin state_d = SQ_ERS_ARM; mode_d = mode_q; end
                        else if (op == OP_IDENT) mode_d = MD_IDENT;
                        else if (op == OP_QUERY) mode_d = MD_QUERY;
                    end
                end
            end
            SQ_WORD: begin
                if (wr_en) begin
                    state_d = SQ_BUSY;
                    mode_d  = MD_READ;
                    act     = ACT_PGM;
                end
            end
            SQ_ERS_ARM: begin
                if (wr_en) begin
                    if (key_a) state_d = SQ_ERS_U1;
                    else begin state_d = SQ_IDLE; mode_d = MD_READ; end
                end
            end
            SQ_ERS_U1: begin
                if (wr_en) begin
                    if (key_b) state_d = SQ_ERS_U2;
                    else begin state_d = SQ_IDLE; mode_d = MD_READ; end
                end
            end
            SQ_ERS_U2: begin
                if (wr_en) begin
                    state_d = SQ_BUSY;
                    mode_d  = MD_READ;
                    if (op == OP_SECTOR)                act = ACT_SEC;
                    else if (op == OP_BLOCK)            act = ACT_BLK;
                    else if (op == OP_CHIP && at_key)   act = ACT_CHIP;
                    else                                state_d = SQ_IDLE;
                end
            end
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= MD_READ;
            pgm_start  <= 1'b0;
            sec_start  <= 1'b0;
            blk_start  <= 1'b0;
            chip_start <= 1'b0;
            tgt_addr   <= '0;
            tgt_data   <= '0;
        end else begin
            mode_q     <= mode_d;
            pgm_start  <= (act == ACT_PGM);
            sec_start  <= (act == ACT_SEC);
            blk_start  <= (act == ACT_BLK);
            chip_start <= (act == ACT_CHIP);
            if (act != ACT_NONE) begin
                tgt_addr <= tgt_fmt;
                tgt_data <= (act == ACT_PGM) ? wr_data : 16'hFFFF;
            end
        end
    end

    assign mode = mode_q;
    assign busy = (state == SQ_BUSY);
endmodule

// File: rtl/nor_cmd_decoder_chk.sv
module nor_cmd_decoder_chk #(
    parameter int ADDR_W    = 21,
    parameter int SECT_BITS = 11
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        mode,
    input logic              pgm_start,
    input logic              sec_start,
    input logic              blk_start,
    input logic              chip_start,
    input logic [ADDR_W-1:0] tgt_addr,
    input logic              busy,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [15:0]       id_word
);
    logic any_start;
    assign any_start = pgm_start | sec_start | blk_start | chip_start;

    // R12
    a_r12_one_kind: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pgm_start, sec_start, blk_start, chip_start}));

    // R12
    a_r12_one_cycle: assert property (@(posedge clk) disable iff (rst)
        any_start |=> !any_start);

    // R10
    a_r10_start_busy: assert property (@(posedge clk) disable iff (rst)
        any_start |-> busy);

    // R10
    a_r10_no_start_in_busy: assert property (@(posedge clk) disable iff (rst)
        any_start |-> !$past(busy));

    // R10
    a_r10_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        $past(busy) |-> $stable(mode));

    // R7
    a_r7_mode_legal: assert property (@(posedge clk) disable iff (rst)
        mode != 2'd3);

    // R6
    a_r6_maker_code: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1 && rd_addr == '0) |-> id_word == 16'h00BF);

    // R5
    a_r5_chip_addr: assert property (@(posedge clk) disable iff (rst)
        chip_start |-> tgt_addr == '0);

    // R3
    a_r3_sector_align: assert property (@(posedge clk) disable iff (rst)
        sec_start |-> tgt_addr[SECT_BITS-1:0] == '0);
endmodule

bind nor_cmd_decoder nor_cmd_decoder_chk #(
    .ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .pgm_start  (pgm_start),
    .sec_start  (sec_start),
    .blk_start  (blk_start),
    .chip_start (chip_start),
    .tgt_addr   (tgt_addr),
    .busy       (busy),
    .rd_addr    (rd_addr),
    .id_word    (id_word)
);

// File: tb/sim_nor_cmd_decoder.sv
module sim_nor_cmd_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 21;
    localparam int CNT_W      = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [15:0]       wr_data = '0;
    logic [CNT_W-1:0]  busy_len = 16'd3;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [1:0]        mode;
    logic              pgm_start, sec_start, blk_start, chip_start, busy;
    logic [ADDR_W-1:0] tgt_addr;
    logic [15:0]       tgt_data, id_word;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nor_cmd_decoder #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy_len(busy_len), .rd_addr(rd_addr), .mode(mode),
        .pgm_start(pgm_start), .sec_start(sec_start), .blk_start(blk_start),
        .chip_start(chip_start), .tgt_addr(tgt_addr), .tgt_data(tgt_data),
        .busy(busy), .id_word(id_word)
    );

    function automatic logic [3:0] pulses();
        return {chip_start, blk_start, sec_start, pgm_start};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        wr(21'h05555, 16'h00AA);
        wr(21'h02AAA, 16'h0055);
    endtask

    task automatic erase_prefix();
        unlock();
        wr(21'h05555, 16'h0080);
        unlock();
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 mode", 32'(mode), 32'd0);
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 pulses", 32'(pulses()), 32'd0);
        check("R1 id_word", 32'(id_word), 32'h0000);
    endtask

    task automatic t_program();
        int n;
        busy_len = 16'd3;
        // R11: upper address and data bits set during the unlock cycles
        wr(21'h1D555, 16'h33AA);
        wr(21'h1AAAA, 16'hC355);
        wr(21'h0D555, 16'h7EA0);
        check("R2 no pulse before word", 32'(pulses()), 32'd0);
        wr(21'h12345, 16'hBEEF);
        check("R2 R11 pgm pulse", 32'(pulses()), 32'b0001);
        check("R2 tgt_addr", 32'(tgt_addr), 32'h12345);
        check("R2 tgt_data", 32'(tgt_data), 32'hBEEF);
        check("R10 busy rises", 32'(busy), 32'd1);
        n = 0;
        while (busy && n < 100) begin
            @(negedge clk);
            n++;
            if (n == 1) check("R12 pulse one cycle", 32'(pulses()), 32'd0);
        end
        check("R10 busy length", 32'(n), 32'd3);
    endtask

    task automatic t_busy_min();
        int n;
        busy_len = 16'd0;
        unlock();
        wr(21'h05555, 16'h00A0);
        wr(21'h00010, 16'h1111);
        n = 0;
        while (busy && n < 100) begin @(negedge clk); n++; end
        check("R10 zero length acts as one", 32'(n), 32'd1);
        busy_len = 16'd3;
    endtask

    task automatic t_sector();
        erase_prefix();
        wr(21'h0ABCD, 16'h0030);
        check("R3 sector pulse", 32'(pulses()), 32'b0010);
        check("R3 sector addr", 32'(tgt_addr), 32'h0A800);
        check("R3 erase data", 32'(tgt_data), 32'hFFFF);
        wait_idle();
    endtask

    task automatic t_block();
        erase_prefix();
        wr(21'h1ABCD, 16'hAB50);
        check("R4 block pulse", 32'(pulses()), 32'b0100);
        check("R4 block addr", 32'(tgt_addr), 32'h18000);
        wait_idle();
    endtask

    task automatic t_chip();
        erase_prefix();
        wr(21'h01234, 16'h0010);
        check("R5 chip wrong addr", 32'(pulses()), 32'd0);
        check("R5 chip wrong addr busy", 32'(busy), 32'd0);
        erase_prefix();
        wr(21'h05555, 16'h0010);
        check("R5 chip pulse", 32'(pulses()), 32'b1000);
        check("R5 chip addr", 32'(tgt_addr), 32'h0);
        wait_idle();
    endtask

    task automatic t_ident();
        unlock();
        wr(21'h05555, 16'h0090);
        check("R6 ident mode", 32'(mode), 32'd1);
        rd_addr = 21'd0; #1;
        check("R6 maker code", 32'(id_word), 32'h00BF);
        rd_addr = 21'd1; #1;
        check("R6 part code", 32'(id_word), 32'h2783);
        rd_addr = 21'd2; #1;
        check("R6 other offset", 32'(id_word), 32'h0000);
        rd_addr = 21'd0;
        wr(21'h00777, 16'h00F0);
        check("R8 single exit", 32'(mode), 32'd0);
        check("R6 read mode id_word", 32'(id_word), 32'h0000);
    endtask

    task automatic t_query();
        unlock();
        wr(21'h05555, 16'h0098);
        check("R7 query mode", 32'(mode), 32'd2);
        unlock();
        check("R8 mode held mid exit", 32'(mode), 32'd2);
        wr(21'h05555, 16'h00F0);
        check("R8 three-cycle exit", 32'(mode), 32'd0);
    endtask

    task automatic t_abort();
        unlock();
        wr(21'h05555, 16'h0090);
        wr(21'h05555, 16'h00AA);
        wr(21'h02AAA, 16'h0000);
        check("R9 abort to read", 32'(mode), 32'd0);
        wr(21'h05555, 16'h00A0);
        wr(21'h00100, 16'h1234);
        check("R9 no program after abort", 32'(pulses()), 32'd0);
        check("R9 no busy after abort", 32'(busy), 32'd0);
        unlock();
        wr(21'h05555, 16'h0080);
        wr(21'h05555, 16'h00AA);
        wr(21'h02AAA, 16'h0056);
        wr(21'h00800, 16'h0030);
        check("R9 erase chain broken", 32'(pulses()), 32'd0);
    endtask

    task automatic t_lockout();
        busy_len = 16'd20;
        erase_prefix();
        wr(21'h05555, 16'h0010);
        check("R10 lockout start", 32'(busy), 32'd1);
        unlock();
        wr(21'h05555, 16'h0090);
        check("R10 still busy", 32'(busy), 32'd1);
        check("R10 ident ignored while busy", 32'(mode), 32'd0);
        wait_idle();
        check("R10 mode after busy", 32'(mode), 32'd0);
        wr(21'h00040, 16'h5678);
        check("R10 sequencer idle after busy", 32'(pulses()), 32'd0);
        busy_len = 16'd3;
    endtask

    initial begin
        t_reset();
        t_program();
        t_busy_min();
        t_sector();
        t_block();
        t_chip();
        t_ident();
        t_query();
        t_abort();
        t_lockout();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule